// File: doc/BRIEF.md
# Routed Frame Header Parser

This block sits on a byte-wide stream and splits each incoming frame into a source-routing header and a payload. The header has no fixed layout. It starts with a list of forward hop identifiers. It may then contain a return-hop list. A terminator byte closes it, and exactly one type byte follows the terminator. The parser walks the header one byte at a time. It counts the hops of each list and remembers the first forward hop. Once the type byte is taken, it presents those fields on sideband outputs.

Payload bytes go out on an output stream with their end-of-frame marker intact. A frame that ends early, carries too many hops, has a second return marker, or arrives with its input error bit set is flagged on the error bit of its final output beat. A frame with no payload still produces one output beat, so the type is delivered. The parser honours backpressure throughout, so it can feed a router or a command decoder directly.

Top module: `route_hdr_parse`

## Requirements
- R1: After reset, out_valid and hdr_valid are low and in_ready is high.
- R2: Header bytes below 0xFE, taken before any 0xFE or 0xFF, are forward hops. hdr_fwd_count gives their number. hdr_first_hop gives the first one, or 0x00 when there are none.
- R3: A 0xFE byte in the forward list switches to the return list. hdr_ret_count gives the number of bytes below 0xFE taken after it. A frame with no 0xFE reports a return count of 0.
- R4: A 0xFF byte ends the header, and the next byte is the type. hdr_valid rises and hdr_type carries that byte in the cycle after the type byte is accepted.
- R5: Bytes after the type byte are sent on out_data in order. out_last is high only on the byte that carried in_last. On a well-formed frame, out_user and out_empty stay low.
- R6: If in_last comes on the type byte, exactly one beat is sent: out_data 0x00, out_last 1, out_empty 1, and out_user 1 only if the frame was bad.
- R7: If in_last comes on any byte before the type byte, the header fields are not published. Exactly one beat is sent: out_data 0x00, out_last 1, out_empty 1, out_user 1.
- R8: Each hop count saturates at 15. A 16th hop in either list marks the frame bad, which sets out_user on its final beat.
- R9: A second 0xFE inside the return list marks the frame bad. That byte is not counted as a hop.
- R10: in_user high on any accepted byte of a frame marks that frame bad.
- R11: The header outputs stay constant while hdr_valid is high. hdr_valid falls in the cycle after the out_last beat is accepted.
- R12: While out_valid is high and out_ready is low, in_ready is low and the output beat holds its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Parser accepts the input byte |
| in_last | input | 1 | Final byte of the input frame |
| in_user | input | 1 | Upstream error mark on the input byte |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_last | output | 1 | Final beat of the frame |
| out_user | output | 1 | Frame bad, valid on the final beat |
| out_empty | output | 1 | Beat carries no payload (type-only or aborted frame) |
| hdr_valid | output | 1 | Header fields valid |
| hdr_first_hop | output | 8 | First forward hop, 0x00 if none |
| hdr_fwd_count | output | 4 | Forward hop count, saturating |
| hdr_ret_count | output | 4 | Return hop count, saturating |
| hdr_type | output | 8 | Type byte |

## Verification
The hardest state to reach is a saturated hop counter. At that point a single extra hop byte must raise the error on a beat many bytes later, while the count stays at 15. The stimulus sends sixteen forward hops in a row before the terminator and checks both the clamped count and the flagged final beat. The backpressure case is the other hard one. The stimulus holds out_ready low while a payload byte sits in the output register and the next byte is offered. It checks that in_ready stays low over several cycles. It then checks that the released byte and the waiting byte both come out in order.

// File: rtl/route_hdr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the routed frame header parser.
// Assumes byte-wide data; the two reserved values are the top two codes.
package route_hdr_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] MARK_RET = 8'hFE;  // forward list ends, return list begins
    localparam logic [BYTE_W-1:0] MARK_END = 8'hFF;  // routing header ends

    typedef enum logic [1:0] {
        PS_FWD  = 2'd0,
        PS_RET  = 2'd1,
        PS_TYPE = 2'd2,
        PS_PAY  = 2'd3
    } parse_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              user;
        logic              empty;
    } out_beat_t;
endpackage

// File: rtl/hop_tally.sv
`timescale 1ns/1ps
// Saturating hop counter.
// Counts increments up to 2**CNT_W-1 and holds there. ovf pulses when an
// increment arrives at the limit. Clear has priority over increment.
module hop_tally #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign ovf = inc && !clr && (cnt == CNT_MAX);

    // Count register with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rhp_fsm.sv
`timescale 1ns/1ps
// Byte-serial header state machine.
// Walks forward list, return list, terminator and type byte, and keeps the
// working hop counts, first hop and bad flag for the frame in progress.
// It issues one push per output beat. It assumes take = valid & ready,
// computed by the caller.
module rhp_fsm
    import route_hdr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_user,
    output logic              push,
    output out_beat_t         push_beat,
    output logic              publish,
    output logic [BYTE_W-1:0] work_first,
    output logic [CNT_W-1:0]  work_fwd,
    output logic [CNT_W-1:0]  work_ret,
    output logic              work_bad
);
    parse_state_t state_q, state_d;
    logic         bad_q;
    logic         fwd_inc, ret_inc, clr;
    logic         fwd_ovf, ret_ovf, dup_ret;
    logic         bad_now;
    logic         is_ret, is_end;

    assign is_ret = (in_data == MARK_RET);
    assign is_end = (in_data == MARK_END);

    hop_tally #(.CNT_W(CNT_W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(fwd_inc),
        .cnt(work_fwd), .ovf(fwd_ovf)
    );
    hop_tally #(.CNT_W(CNT_W)) u_ret (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(ret_inc),
        .cnt(work_ret), .ovf(ret_ovf)
    );

    assign bad_now  = bad_q || fwd_ovf || ret_ovf || dup_ret || (take && in_user);
    assign work_bad = bad_q;

    // Next state, counter strobes and output beat for the accepted byte
    always_comb begin
        state_d   = state_q;
        fwd_inc   = 1'b0;
        ret_inc   = 1'b0;
        dup_ret   = 1'b0;
        clr       = 1'b0;
        push      = 1'b0;
        publish   = 1'b0;
        push_beat = '{data: '0, last: 1'b1, user: 1'b1, empty: 1'b1};
        if (take) begin
            unique case (state_q)
                PS_FWD: begin
                    if (is_end)      state_d = PS_TYPE;
                    else if (is_ret) state_d = PS_RET;
                    else             fwd_inc = 1'b1;
                end
                PS_RET: begin
                    if (is_end)      state_d = PS_TYPE;
                    else if (is_ret) dup_ret = 1'b1;
                    else             ret_inc = 1'b1;
                end
                PS_TYPE: begin
                    publish = 1'b1;
                    if (in_last) begin
                        push           = 1'b1;
                        push_beat.user = bad_now;
                    end else begin
                        state_d = PS_PAY;
                    end
                end
                PS_PAY: begin
                    push            = 1'b1;
                    push_beat.data  = in_data;
                    push_beat.last  = in_last;
                    push_beat.user  = bad_now && in_last;
                    push_beat.empty = 1'b0;
                end
                default: state_d = PS_FWD;
            endcase
            // Early end in the header: send an aborted empty beat
            if (in_last && (state_q == PS_FWD || state_q == PS_RET)) begin
                push = 1'b1;
            end
            if (in_last) begin
                clr     = 1'b1;
                state_d = PS_FWD;
            end
        end
    end

    // State and frame bad flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_FWD;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr)
                bad_q <= 1'b0;
            else
                bad_q <= bad_now;
        end
    end

    // First forward hop capture
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            work_first <= '0;
        else if (fwd_inc && work_fwd == '0)
            work_first <= in_data;
    end
endmodule

// File: rtl/rhp_out_stage.sv
`timescale 1ns/1ps
// Single output register for the payload stream.
// A push loads a new beat. A beat leaves when out_ready is high.
// Assumes push only occurs when space is free (space = !valid | ready).
module rhp_out_stage
    import route_hdr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  out_beat_t push_beat,
    input  logic      out_ready,
    output logic      space,
    output logic      out_valid,
    output out_beat_t out_beat
);
    assign space = !out_valid || out_ready;

    // Beat valid flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (push)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Beat contents, loaded on push
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_beat <= '0;
        else if (push)
            out_beat <= push_beat;
    end
endmodule

// File: rtl/route_hdr_parse.sv
`timescale 1ns/1ps
// Routed frame header parser, top level.
// Parses a variable-length source-route header and a type byte, publishes
// the header fields, and forwards the payload with framing and error mark.
// Assumes one byte per beat and a downstream that accepts with out_ready.
module route_hdr_parse
    import route_hdr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_last,
    input  logic             in_user,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic             out_user,
    output logic             out_empty,
    output logic             hdr_valid,
    output logic [7:0]       hdr_first_hop,
    output logic [CNT_W-1:0] hdr_fwd_count,
    output logic [CNT_W-1:0] hdr_ret_count,
    output logic [7:0]       hdr_type
);
    logic              take, push, publish, work_bad;
    out_beat_t         push_beat, beat_q;
    logic [BYTE_W-1:0] work_first;
    logic [CNT_W-1:0]  work_fwd, work_ret;

    assign take = in_valid && in_ready;

    rhp_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .take(take),
        .in_data(in_data), .in_last(in_last), .in_user(in_user),
        .push(push), .push_beat(push_beat), .publish(publish),
        .work_first(work_first), .work_fwd(work_fwd), .work_ret(work_ret),
        .work_bad(work_bad)
    );

    rhp_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .push(push), .push_beat(push_beat),
        .out_ready(out_ready), .space(in_ready),
        .out_valid(out_valid), .out_beat(beat_q)
    );

    assign out_data  = beat_q.data;
    assign out_last  = beat_q.last;
    assign out_user  = beat_q.user;
    assign out_empty = beat_q.empty;

    // Header field publication, held until the final beat leaves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_valid     <= 1'b0;
            hdr_first_hop <= '0;
            hdr_fwd_count <= '0;
            hdr_ret_count <= '0;
            hdr_type      <= '0;
        end else if (publish) begin
            hdr_valid     <= 1'b1;
            hdr_first_hop <= work_first;
            hdr_fwd_count <= work_fwd;
            hdr_ret_count <= work_ret;
            hdr_type      <= in_data;
        end else if (out_valid && out_ready && out_last) begin
            hdr_valid     <= 1'b0;
        end
    end

    // The bad flag is folded into beats inside the state machine
    logic unused_bad;
    assign unused_bad = work_bad;
endmodule

// File: rtl/rhp_checker.sv
`timescale 1ns/1ps
// Protocol checks for route_hdr_parse, attached through bind.
module rhp_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic [7:0]       out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic             out_user,
    input logic             out_empty,
    input logic             hdr_valid,
    input logic [7:0]       hdr_first_hop,
    input logic [CNT_W-1:0] hdr_fwd_count,
    input logic [CNT_W-1:0] hdr_ret_count,
    input logic [7:0]       hdr_type
);
    // R12: a stalled beat holds and no byte is taken
    a_r12_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_last) && $stable(out_user) && $stable(out_empty));

    a_r12_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R6, R7: empty beats are always final beats
    a_r6_empty_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty |-> out_last);

    // R8: the error mark only appears on a final beat
    a_r8_user_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_user |-> out_last);

    // R11: header fields stay constant until the final beat leaves
    a_r11_hdr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !(out_valid && out_ready && out_last) |=> hdr_valid
            && $stable(hdr_type) && $stable(hdr_first_hop)
            && $stable(hdr_fwd_count) && $stable(hdr_ret_count));

    // R11: hdr_valid drops after the final beat handshake
    a_r11_hdr_drop: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && out_valid && out_ready && out_last |=> !hdr_valid);
endmodule

bind route_hdr_parse rhp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_user(out_user), .out_empty(out_empty),
    .hdr_valid(hdr_valid), .hdr_first_hop(hdr_first_hop),
    .hdr_fwd_count(hdr_fwd_count), .hdr_ret_count(hdr_ret_count),
    .hdr_type(hdr_type)
);

// File: tb/sim_route_hdr_parse.sv
`timescale 1ns/1ps
module sim_route_hdr_parse;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0, in_last = 1'b0, in_user = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid, out_last, out_user, out_empty;
    logic       out_ready = 1'b1;
    logic       hdr_valid;
    logic [7:0] hdr_first_hop, hdr_type;
    logic [3:0] hdr_fwd_count, hdr_ret_count;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    route_hdr_parse u0 (.*);

    // Output beat capture at each handshake
    logic [7:0] cap_data [0:31];
    logic       cap_last [0:31];
    logic       cap_user [0:31];
    logic       cap_empty[0:31];
    int         cap_n = 0;
    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready && cap_n < 32) begin
            cap_data[cap_n]  <= out_data;
            cap_last[cap_n]  <= out_last;
            cap_user[cap_n]  <= out_user;
            cap_empty[cap_n] <= out_empty;
            cap_n <= cap_n + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic l, input logic u = 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = l; in_user = u;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle_wait();
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_user = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_frame();
        @(negedge clk);
        cap_n = 0;
    endtask

    task automatic check_beat(input string req, input int i, input int d, input int l,
                              input int u, input int e);
        check(req, $sformatf("beat%0d data", i), cap_data[i], d);
        check(req, $sformatf("beat%0d last", i), cap_last[i], l);
        check(req, $sformatf("beat%0d user", i), cap_user[i], u);
        check(req, $sformatf("beat%0d empty", i), cap_empty[i], e);
    endtask

    task automatic t_reset();
        check("R1", "out_valid", out_valid, 0);
        check("R1", "hdr_valid", hdr_valid, 0);
        check("R1", "in_ready", in_ready, 1);
    endtask

    // R2 R3 R4 R5 R11: full header with return list
    task automatic t_basic();
        start_frame();
        send(8'h01, 0); send(8'h02, 0); send(8'h03, 0); send(8'hFE, 0);
        send(8'h04, 0); send(8'hFF, 0); send(8'h05, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4", "hdr_valid after type", hdr_valid, 1);
        check("R4", "type", hdr_type, 8'h05);
        check("R2", "first hop", hdr_first_hop, 8'h01);
        check("R2", "fwd count", hdr_fwd_count, 3);
        check("R3", "ret count", hdr_ret_count, 1);
        send(8'hAA, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "hdr_valid in payload", hdr_valid, 1);
        send(8'hBB, 1);
        idle_wait();
        check("R5", "beat count", cap_n, 2);
        check_beat("R5", 0, 8'hAA, 0, 0, 0);
        check_beat("R5", 1, 8'hBB, 1, 0, 0);
        check("R11", "hdr_valid after last", hdr_valid, 0);
        check("R11", "type held", hdr_type, 8'h05);
    endtask

    // R3: no return section
    task automatic t_no_ret();
        start_frame();
        send(8'h07, 0); send(8'hFF, 0); send(8'h09, 0); send(8'h11, 1);
        idle_wait();
        check("R3", "ret count zero", hdr_ret_count, 0);
        check("R2", "fwd count one", hdr_fwd_count, 1);
        check("R4", "type", hdr_type, 8'h09);
        check("R5", "beat count", cap_n, 1);
        check_beat("R5", 0, 8'h11, 1, 0, 0);
    endtask

    // R2: no forward hops
    task automatic t_no_fwd();
        start_frame();
        send(8'hFF, 0); send(8'h07, 0); send(8'h55, 1);
        idle_wait();
        check("R2", "first hop none", hdr_first_hop, 0);
        check("R2", "fwd count zero", hdr_fwd_count, 0);
        check_beat("R5", 0, 8'h55, 1, 0, 0);
    endtask

    // R6: type byte carries last
    task automatic t_empty();
        start_frame();
        send(8'h03, 0); send(8'hFF, 0); send(8'h22, 1);
        idle_wait();
        check("R6", "beat count", cap_n, 1);
        check_beat("R6", 0, 0, 1, 0, 1);
        check("R6", "type", hdr_type, 8'h22);
    endtask

    // R7: early end in forward list and on terminator
    task automatic t_early();
        start_frame();
        send(8'h01, 0); send(8'h02, 1);
        idle_wait();
        check("R7", "beat count hop", cap_n, 1);
        check_beat("R7", 0, 0, 1, 1, 1);
        check("R7", "hdr_valid stays low", hdr_valid, 0);
        start_frame();
        send(8'h01, 0); send(8'hFF, 1);
        idle_wait();
        check("R7", "beat count term", cap_n, 1);
        check_beat("R7", 0, 0, 1, 1, 1);
        check("R7", "hdr_valid stays low term", hdr_valid, 0);
    endtask

    // R8: sixteen forward hops
    task automatic t_overflow();
        start_frame();
        for (int i = 1; i <= 16; i++) send(8'(i), 0);
        send(8'hFF, 0); send(8'h44, 0); send(8'h99, 1);
        idle_wait();
        check("R8", "fwd count clamp", hdr_fwd_count, 15);
        check("R8", "first hop", hdr_first_hop, 1);
        check("R8", "beat count", cap_n, 1);
        check_beat("R8", 0, 8'h99, 1, 1, 0);
    endtask

    // R9: second return marker
    task automatic t_dup_ret();
        start_frame();
        send(8'h01, 0); send(8'hFE, 0); send(8'h02, 0); send(8'hFE, 0);
        send(8'h03, 0); send(8'hFF, 0); send(8'h05, 0); send(8'h66, 1);
        idle_wait();
        check("R9", "ret count", hdr_ret_count, 2);
        check_beat("R9", 0, 8'h66, 1, 1, 0);
    endtask

    // R10: upstream error mark
    task automatic t_in_user();
        start_frame();
        send(8'h01, 0); send(8'hFF, 0); send(8'h05, 0);
        send(8'h10, 0, 1'b1); send(8'h20, 1);
        idle_wait();
        check("R10", "beat count", cap_n, 2);
        check_beat("R10", 0, 8'h10, 0, 0, 0);
        check_beat("R10", 1, 8'h20, 1, 1, 0);
    endtask

    // R12: stalled output holds input back
    task automatic t_backpressure();
        start_frame();
        out_ready = 1'b0;
        send(8'h01, 0); send(8'hFF, 0); send(8'h05, 0); send(8'hA1, 0);
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hA2; in_last = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R12", "in_ready low", in_ready, 0);
            check("R12", "held data", out_data, 8'hA1);
        end
        out_ready = 1'b1;
        @(posedge clk);
        send(8'hA3, 1);
        idle_wait();
        check("R12", "beat count", cap_n, 3);
        check_beat("R12", 0, 8'hA1, 0, 0, 0);
        check_beat("R12", 1, 8'hA2, 0, 0, 0);
        check_beat("R12", 2, 8'hA3, 1, 0, 0);
    endtask

    bit done = 1'b0;
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_ret();
        t_no_fwd();
        t_empty();
        t_early();
        t_overflow();
        t_dup_ret();
        t_in_user();
        t_backpressure();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule